// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is a synchronous serial slave that gives a host access to the small register file of a data converter. The host pulls chip select low and clocks bits in and out with a serial clock. Every communication cycle opens with one 8-bit command byte. That byte sets the direction, how many data bytes follow (one to four), the target register and the byte of that register to start at. The data bytes then move through the port. After each byte the port steps the byte pointer up or down, and each byte is shifted with the least or the most significant bit first. Both choices come from bits of a control register that the host can itself write.

The serial clock, chip select and data input are oversampled in the system clock domain. Input bits are taken on the rising serial-clock edge and output bits change on the falling edge. Read data goes out on the shared data pin (two-wire mode) or on a dedicated output pin (three-wire mode). The control register picks the mode. A 24-bit conversion result register is loaded from the converter side. A control register and two calibration registers are exported to the converter core.

Top module: `sreg_port`

## Requirements
- R1: After chip select falls, the first 8 bits received form the command byte, shifted most significant bit first, and all data-phase activity follows from that byte.
- R2: Command bit 7 sets the direction: 1 writes the data bytes into the register file and 0 returns register bytes to the host.
- R3: Command bits 6:5 hold the data byte count minus one, so 00 moves one byte and 11 moves four.
- R4: Command bits 3:2 pick the register: 00 is the result register, 01 the control register, 10 a calibration register and 11 nothing (reads zero, writes ignored). With 10, bit 4 chooses the positive (0) or negative (1) calibration register. Bits 1:0 give the starting byte, where byte 0 is register bits 7:0.
- R5: With control bit 1 at 0 the byte pointer decrements after each byte, and with control bit 0 at 0 each data byte is shifted most significant bit first.
- R6: With control bit 1 at 1 the byte pointer increments after each byte, and with control bit 0 at 1 each data byte is shifted least significant bit first.
- R7: Read bits change after falling serial-clock edges. With control bit 2 at 0 they appear on sdio_o with sdio_oe high. With control bit 2 at 1 they appear on sdo, and sdio_oe stays low.
- R8: The result register loads conv_data when conv_load is high and ignores writes from the serial side.
- R9: Byte address 3 of any register reads as zero and ignores writes.
- R10: After the last data byte the port returns to standby, and the next 8 bits are taken as a new command byte even if chip select stays low.
- R11: Raising chip select aborts the cycle, discards a partially received byte and returns to standby. This holds even when the rise arrives together with the 8th rising clock edge of a write byte.
- R12: Reset clears the control and calibration registers and drives sdio_oe, sdio_o and sdo low. A written byte changes the register file only once all 8 of its bits have arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Read data for the shared pin (two-wire mode) |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data pin in three-wire mode |
| conv_load | input | 1 | Loads the result register |
| conv_data | input | REG_W | New conversion result |
| ctrl_o | output | REG_W | Control register contents |
| pcal_o | output | REG_W | Positive full-scale calibration register |
| ncal_o | output | REG_W | Negative full-scale calibration register |

## Verification
The case that needs care is a chip-select release that reaches the port in the same system-clock cycle as the rising edge that completes a write byte. Both signals pass through synchronizers of equal length, so raising them in the same time step makes the abort and the byte commit meet in one cycle. The bench judges the outcome at the ports. The calibration register output must keep its old value, and the next full write cycle must land normally, which shows the port went back to standby.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_CTRL,
    SEL_PCAL,
    SEL_NCAL,
    SEL_NONE
  } reg_sel_e;

  typedef enum logic {
    PH_INSTR,
    PH_DATA
  } phase_e;

  typedef struct packed {
    logic      is_wr;
    logic [1:0] extra;   // byte count minus one
    reg_sel_e  sel;
    logic [1:0] ptr;
  } instr_t;

  localparam int CTRL_LSB_BIT = 0;
  localparam int CTRL_ASC_BIT = 1;
  localparam int CTRL_3W_BIT  = 2;

  function automatic instr_t decode_instr(input logic [7:0] b);
    instr_t d;
    d.is_wr = b[7];
    d.extra = b[6:5];
    d.ptr   = b[1:0];
    case (b[3:2])
      2'b00:   d.sel = SEL_DATA;
      2'b01:   d.sel = SEL_CTRL;
      2'b10:   d.sel = b[4] ? SEL_NCAL : SEL_PCAL;
      default: d.sel = SEL_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdio_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din
);

  logic [STAGES-1:0] sclk_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] din_p;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      din_p  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
      din_p  <= {din_p[STAGES-2:0], sdio_i};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
  assign cs_act    = ~cs_p[STAGES-1];
  assign din       = din_p[STAGES-1];

endmodule

// File: rtl/sreg_regs.sv
`timescale 1ns/1ps
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_load,
  input  logic [REG_W-1:0] conv_data,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [1:0]       wr_ptr,
  input  logic [7:0]       wr_data,
  input  reg_sel_e         rd_sel,
  input  logic [1:0]       rd_ptr,
  output logic [7:0]       rd_byte,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] pcal_o,
  output logic [REG_W-1:0] ncal_o
);

  localparam int NB   = REG_W / 8;
  localparam int NWR  = 3;

  logic [REG_W-1:0] data_q;
  logic [REG_W-1:0] wreg_q [NWR];
  logic [NWR-1:0]   wr_hit;
  logic [REG_W-1:0] rd_src;

  assign wr_hit = {wr_sel == SEL_NCAL, wr_sel == SEL_PCAL, wr_sel == SEL_CTRL};

  always_ff @(posedge clk) begin
    if (rst)            data_q <= '0;
    else if (conv_load) data_q <= conv_data;
  end

  for (genvar r = 0; r < NWR; r++) begin : g_wreg
    always_ff @(posedge clk) begin
      if (rst) begin
        wreg_q[r] <= '0;
      end else if (wr_en && wr_hit[r]) begin
        for (int b = 0; b < NB; b++) begin
          if (wr_ptr == 2'(b)) wreg_q[r][b*8 +: 8] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_DATA: rd_src = data_q;
      SEL_CTRL: rd_src = wreg_q[0];
      SEL_PCAL: rd_src = wreg_q[1];
      SEL_NCAL: rd_src = wreg_q[2];
      default:  rd_src = '0;
    endcase
    rd_byte = 8'h00;
    for (int b = 0; b < NB; b++) begin
      if (rd_ptr == 2'(b)) rd_byte = rd_src[b*8 +: 8];
    end
  end

  assign ctrl_o = wreg_q[0];
  assign pcal_o = wreg_q[1];
  assign ncal_o = wreg_q[2];

  // R8: serial writes never touch the result register
  a_r8_data_readonly: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_DATA && !conv_load) |=> $stable(data_q));

  // R9: byte address beyond the register width changes nothing
  a_r9_high_byte_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ({1'b0, wr_ptr} >= 3'(NB)))
      |=> ($stable(wreg_q[0]) && $stable(wreg_q[1]) && $stable(wreg_q[2])));

endmodule

// File: rtl/sreg_engine.sv
`timescale 1ns/1ps
module sreg_engine
  import sreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       fall,
  input  logic       cs_act,
  input  logic       din,
  input  logic       lsb_first,
  input  logic       ascending,
  input  logic       three_wire,
  input  logic [7:0] rd_byte,
  output reg_sel_e   rd_sel,
  output logic [1:0] rd_ptr,
  output logic       wr_en,
  output reg_sel_e   wr_sel,
  output logic [1:0] wr_ptr,
  output logic [7:0] wr_data,
  output logic       sdio_o,
  output logic       sdio_oe,
  output logic       sdo
);

  phase_e     phase_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] sh_q;
  logic       is_wr_q;
  logic [1:0] left_q;
  reg_sel_e   sel_q;
  logic [1:0] ptr_q;

  logic [7:0] in_msb;
  logic [7:0] in_lsb;
  logic       byte_done;
  logic [2:0] tx_idx;
  logic       tx_bit;
  instr_t     dec;

  assign in_msb    = {sh_q[6:0], din};
  assign in_lsb    = {din, sh_q[7:1]};
  assign byte_done = rise && (bit_cnt_q == 3'd7);
  assign dec       = decode_instr(in_msb);
  assign tx_idx    = lsb_first ? bit_cnt_q : (3'd7 - bit_cnt_q);
  assign tx_bit    = rd_byte[tx_idx];

  assign wr_en   = cs_act && byte_done && (phase_q == PH_DATA) && is_wr_q;
  assign wr_data = lsb_first ? in_lsb : in_msb;
  assign wr_sel  = sel_q;
  assign wr_ptr  = ptr_q;
  assign rd_sel  = sel_q;
  assign rd_ptr  = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_INSTR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      is_wr_q   <= 1'b0;
      left_q    <= '0;
      sel_q     <= SEL_NONE;
      ptr_q     <= '0;
      sdio_o    <= 1'b0;
      sdio_oe   <= 1'b0;
      sdo       <= 1'b0;
    end else if (!cs_act) begin
      phase_q   <= PH_INSTR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      sdio_o    <= 1'b0;
      sdio_oe   <= 1'b0;
      sdo       <= 1'b0;
    end else if (rise) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      sh_q      <= (phase_q == PH_DATA && lsb_first) ? in_lsb : in_msb;
      if (byte_done) begin
        if (phase_q == PH_INSTR) begin
          is_wr_q <= dec.is_wr;
          left_q  <= dec.extra;
          sel_q   <= dec.sel;
          ptr_q   <= dec.ptr;
          phase_q <= PH_DATA;
        end else begin
          ptr_q <= ascending ? (ptr_q + 2'd1) : (ptr_q - 2'd1);
          if (left_q == 2'd0) phase_q <= PH_INSTR;
          else                left_q  <= left_q - 2'd1;
        end
      end
    end else if (fall) begin
      if (phase_q == PH_DATA && !is_wr_q) begin
        if (three_wire) begin
          sdo     <= tx_bit;
          sdio_o  <= 1'b0;
          sdio_oe <= 1'b0;
        end else begin
          sdo     <= 1'b0;
          sdio_o  <= tx_bit;
          sdio_oe <= 1'b1;
        end
      end else begin
        sdo     <= 1'b0;
        sdio_o  <= 1'b0;
        sdio_oe <= 1'b0;
      end
    end
  end

  // R11: a released chip select leaves the port in standby
  a_r11_abort_to_standby: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (phase_q == PH_INSTR && bit_cnt_q == 3'd0));

  // R1: the bit counter only advances on rising serial-clock edges
  a_r1_count_on_rise_only: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !rise) |=> $stable(bit_cnt_q));

  // R7: the shared pin is driven only for read cycles
  a_r7_oe_read_only: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> !is_wr_q);

  // R7: the two output paths are never active together
  a_r7_one_output_path: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> !sdo);

endmodule

// File: rtl/sreg_port.sv
`timescale 1ns/1ps
module sreg_port
  import sreg_pkg::*;
#(
  parameter int REG_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo,
  input  logic             conv_load,
  input  logic [REG_W-1:0] conv_data,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] pcal_o,
  output logic [REG_W-1:0] ncal_o
);

  logic       sclk_rise;
  logic       sclk_fall;
  logic       cs_act;
  logic       din;
  logic       wr_en;
  reg_sel_e   wr_sel;
  reg_sel_e   rd_sel;
  logic [1:0] wr_ptr;
  logic [1:0] rd_ptr;
  logic [7:0] wr_data;
  logic [7:0] rd_byte;

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sclk),
    .cs_n_i    (cs_n),
    .sdio_i    (sdio_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .din       (din)
  );

  sreg_engine u_engine (
    .clk        (clk),
    .rst        (rst),
    .rise       (sclk_rise),
    .fall       (sclk_fall),
    .cs_act     (cs_act),
    .din        (din),
    .lsb_first  (ctrl_o[CTRL_LSB_BIT]),
    .ascending  (ctrl_o[CTRL_ASC_BIT]),
    .three_wire (ctrl_o[CTRL_3W_BIT]),
    .rd_byte    (rd_byte),
    .rd_sel     (rd_sel),
    .rd_ptr     (rd_ptr),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_ptr     (wr_ptr),
    .wr_data    (wr_data),
    .sdio_o     (sdio_o),
    .sdio_oe    (sdio_oe),
    .sdo        (sdo)
  );

  sreg_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .conv_load (conv_load),
    .conv_data (conv_data),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_ptr    (rd_ptr),
    .rd_byte   (rd_byte),
    .ctrl_o    (ctrl_o),
    .pcal_o    (pcal_o),
    .ncal_o    (ncal_o)
  );

  // R12: a byte is committed only on the rising edge that completes it
  a_r12_commit_on_rise: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sclk_rise && cs_act));

endmodule

// File: tb/sreg_port_tb.sv
`timescale 1ns/1ps
module sreg_port_tb;

  localparam int  REG_W = 24;
  localparam time HALF  = 40ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo;
  logic conv_load = 1'b0;
  logic [REG_W-1:0] conv_data = '0;
  logic [REG_W-1:0] ctrl_o, pcal_o, ncal_o;

  int checks = 0;
  int fails  = 0;
  bit lsb_mode = 1'b0;
  bit tw_mode  = 1'b0;
  bit oe_seen  = 1'b0;

  always #2ns clk = ~clk;

  sreg_port #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
    .conv_load(conv_load), .conv_data(conv_data),
    .ctrl_o(ctrl_o), .pcal_o(pcal_o), .ncal_o(ncal_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] tx, input bit lsb, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      sdio_i = tx[idx];
      #HALF;
      rx[idx] = tw_mode ? sdo : sdio_o;
      if (sdio_oe) oe_seen = 1'b1;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_end();
    #HALF;
    cs_n = 1'b1;
    #(HALF * 2);
  endtask

  task automatic cmd(input logic [7:0] instr, input int n, input logic [31:0] wb, output logic [31:0] rb);
    logic [7:0] r;
    rb = '0;
    shift_bits(instr, 1'b0, 8, r);
    for (int k = 0; k < n; k++) begin
      shift_bits(wb[k*8 +: 8], lsb_mode, 8, r);
      rb[k*8 +: 8] = r;
    end
  endtask

  task automatic xfer(input logic [7:0] instr, input int n, input logic [31:0] wb, output logic [31:0] rb);
    cs_begin();
    cmd(instr, n, wb, rb);
    cs_end();
  endtask

  task automatic t_reset();
    chk(ctrl_o == 0, "R12 reset ctrl", ctrl_o, 0);
    chk(pcal_o == 0 && ncal_o == 0, "R12 reset cal", {8'h0, pcal_o | ncal_o}, 0);
    chk(!sdio_oe && !sdo && !sdio_o, "R12 reset outputs", {sdio_oe, sdo, sdio_o}, 0);
  endtask

  task automatic t_write_desc();
    logic [31:0] rb;
    xfer(8'hCA, 3, 32'h00CCBBAA, rb);   // write, 3 bytes, pos cal, start byte 2
    chk(pcal_o == 24'hAABBCC, "R2 R3 R5 descending msb-first write", pcal_o, 32'hAABBCC);
    xfer(8'hDA, 3, 32'h00332211, rb);   // same with bit 4 set: neg cal
    chk(ncal_o == 24'h112233, "R4 negative cal select", ncal_o, 32'h112233);
    chk(pcal_o == 24'hAABBCC, "R4 positive cal untouched", pcal_o, 32'hAABBCC);
  endtask

  task automatic t_read_data();
    logic [31:0] rb;
    oe_seen = 1'b0;
    xfer(8'h42, 3, 0, rb);               // read, 3 bytes, result reg, start byte 2
    chk(rb == 32'h00963C5A, "R1 R2 R8 result read two-wire", rb, 32'h00963C5A);
    chk(oe_seen, "R7 sdio_oe high in two-wire read", oe_seen, 1);
    chk(!sdio_oe, "R7 sdio_oe released after cycle", sdio_oe, 0);
    xfer(8'h80, 1, 32'h00000000, rb);    // write attempt to result reg byte 0
    xfer(8'h42, 3, 0, rb);
    chk(rb == 32'h00963C5A, "R8 result register ignores writes", rb, 32'h00963C5A);
  endtask

  task automatic t_byte3();
    logic [31:0] rb;
    xfer(8'h9B, 1, 32'h000000FF, rb);    // write neg cal byte 3
    xfer(8'h5A, 3, 0, rb);               // read neg cal from byte 2
    chk(rb == 32'h00332211, "R9 byte 3 write ignored", rb, 32'h00332211);
    xfer(8'h0B, 1, 0, rb);               // read pos cal byte 3
    chk(rb == 32'h0, "R9 byte 3 reads zero", rb, 0);
    xfer(8'h0C, 1, 0, rb);               // register select 11
    chk(rb == 32'h0, "R4 unused register reads zero", rb, 0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] rb;
    cs_begin();
    cmd(8'h88, 1, 32'h00000077, rb);     // write pos cal byte 0
    cmd(8'h08, 1, 0, rb);                // read pos cal byte 0, same select
    cs_end();
    chk(rb == 32'h00000077, "R10 next byte is a new command", rb, 32'h77);
    chk(pcal_o == 24'hAABB77, "R10 first command committed", pcal_o, 32'hAABB77);
  endtask

  task automatic t_ascending();
    logic [31:0] rb;
    xfer(8'h84, 1, 32'h00000003, rb);    // control byte 0 = asc + lsb-first
    chk(ctrl_o == 24'h000003, "R4 control register write", ctrl_o, 3);
    lsb_mode = 1'b1;
    xfer(8'h68, 4, 0, rb);               // read 4 bytes pos cal from byte 0
    chk(rb == 32'h00AABB77, "R3 R6 four-byte ascending lsb-first read", rb, 32'h00AABB77);
    xfer(8'hA8, 2, 32'h00003412, rb);    // write 2 bytes pos cal from byte 0
    chk(pcal_o == 24'hAA3412, "R6 ascending lsb-first write", pcal_o, 32'hAA3412);
  endtask

  task automatic t_three_wire();
    logic [31:0] rb;
    xfer(8'h84, 1, 32'h00000007, rb);    // add three-wire bit
    tw_mode = 1'b1;
    chk(ctrl_o == 24'h000007, "R7 three-wire mode set", ctrl_o, 7);
    oe_seen = 1'b0;
    xfer(8'h40, 3, 0, rb);
    chk(rb == 32'h005A3C96, "R7 three-wire read on sdo", rb, 32'h005A3C96);
    chk(!oe_seen, "R7 sdio_oe low in three-wire", oe_seen, 0);
    xfer(8'h84, 1, 32'h00000000, rb);
    tw_mode  = 1'b0;
    lsb_mode = 1'b0;
    chk(ctrl_o == 24'h0, "R5 control back to defaults", ctrl_o, 0);
  endtask

  task automatic t_abort();
    logic [7:0]  r;
    logic [31:0] rb;
    cs_begin();
    shift_bits(8'h88, 1'b0, 8, r);
    shift_bits(8'h00, 1'b0, 4, r);
    cs_end();
    chk(pcal_o == 24'hAA3412, "R11 mid-byte abort discards", pcal_o, 32'hAA3412);
    cs_begin();
    shift_bits(8'h88, 1'b0, 8, r);
    shift_bits(8'h00, 1'b0, 7, r);
    #(HALF / 2);
    chk(pcal_o == 24'hAA3412, "R12 no commit before 8th bit", pcal_o, 32'hAA3412);
    #(HALF / 2);
    sdio_i = 1'b0;
    #HALF;
    sclk = 1'b1;
    cs_n = 1'b1;                          // abort together with 8th rising edge
    #HALF;
    sclk = 1'b0;
    #(HALF * 2);
    chk(pcal_o == 24'hAA3412, "R11 coincident abort discards", pcal_o, 32'hAA3412);
    xfer(8'h88, 1, 32'h00000055, rb);
    chk(pcal_o == 24'hAA3455, "R11 standby after abort", pcal_o, 32'hAA3455);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    #1ns rst = 1'b0;
    #20ns;
    t_reset();
    conv_data = 24'h5A3C96;
    conv_load = 1'b1;
    #4ns conv_load = 1'b0;
    #20ns;
    t_write_desc();
    t_read_data();
    t_byte3();
    t_back_to_back();
    t_ascending();
    t_three_wire();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule